// File: doc/BRIEF.md
# Flash Program and Erase Sequencer

This block is the host-side controller for an asynchronous byte-wide flash device. A client raises a single-cycle request naming an operation (program one byte, erase one sector, erase the whole chip), a target address, a data byte and a completion-check method. The sequencer then drives the flash bus through the fixed series of unlock and command write cycles for that operation. Every bus phase is a parameter in clock cycles: address/data setup, write-enable low width, write-enable high time with hold, output-enable low time, and read recovery.

Once the last command write has completed, the block repeatedly reads the target address and watches the two status bits of the data bus. In data-polling mode the read bit 7 must equal the expected bit 7. In toggle mode two consecutive reads must return the same bit 6. A per-operation cycle budget bounds the wait. The block reports the result with a one-cycle `done` or `timeout` pulse, and `busy` covers the whole operation. Only the two status bits of the read data are brought into the block.

Top module: `flash_seq`

## Requirements
- R1: A request is taken only when `busy` is low and `req_op` is a legal code (0 = byte program, 1 = sector erase, 2 = chip erase). Code 3, or any request while `busy` is high, causes no bus activity and does not change `busy`.
- R2: `busy` rises in the cycle after the accepting clock edge. It falls in the same cycle as a one-cycle `done` or `timeout` pulse. `done` and `timeout` are never high together.
- R3: A byte program issues exactly four writes as (address, data): (5555h, AAh), (2AAAh, 55h), (5555h, A0h), then (target, data).
- R4: An erase issues exactly six writes: (5555h, AAh), (2AAAh, 55h), (5555h, 80h), (5555h, AAh), (2AAAh, 55h), then (5555h, 10h) for chip erase or (target, 30h) for sector erase.
- R5: In each write cycle, CE is low and the address and data are driven for T_AS cycles before WE falls. WE stays low for T_WP cycles. Address, data and CE hold for T_WPH cycles after WE rises. OE is high throughout.
- R6: WE first goes low T_AS+1 cycles after the accepting edge, and CE goes low one cycle after that edge.
- R7: In each status read, the data drive is off for at least one cycle before OE falls. WE is high, OE is low for T_OE cycles, and the status bits are sampled at the end of that window.
- R8: In data-polling mode (`req_toggle` = 0), the block reports `done` after the first read whose bit 7 equals the data bit 7 for a program, or equals 1 for an erase.
- R9: In toggle mode (`req_toggle` = 1), the block reports `done` after a read whose bit 6 equals bit 6 of the previous read of the same operation. The first read can never complete the operation.
- R10: If a status read fails and at least TO_PROG, TO_SECT or TO_CHIP cycles (selected by the operation) have passed since polling began, `timeout` is pulsed instead of `done`.
- R11: After reset, `busy`, `done`, `timeout` and the data drive enable are low, and CE, OE and WE are high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe |
| req_op | input | 2 | Operation code (0 program, 1 sector erase, 2 chip erase) |
| req_addr | input | AW | Target byte or sector address |
| req_data | input | 8 | Byte to program |
| req_toggle | input | 1 | Completion method: 0 bit-7 polling, 1 bit-6 toggle |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse on successful completion |
| timeout | output | 1 | One-cycle pulse when the cycle budget ran out |
| fl_addr | output | AW | Flash address bus |
| fl_dout | output | 8 | Flash write data |
| fl_dout_en | output | 1 | Write data drive enable |
| fl_stat | input | 2 | Flash data bits 7 and 6 during reads |
| fl_ce_n | output | 1 | Chip enable, active low |
| fl_oe_n | output | 1 | Output enable, active low |
| fl_we_n | output | 1 | Write enable, active low |

## Verification
The bench drives requests and samples all ports one nanosecond after the falling clock edge. `busy` is therefore checked at the first falling edge after the accepting rising edge. CE is checked one edge later, and the WE fall exactly T_AS+1 edges after acceptance, with WE confirmed high at every earlier sample. A flash model samples the bus at the same falling edges. It captures each write's address at the WE fall and its data at the WE rise, and it flags any break in setup, width, hold or turnaround in the cycle where it occurs. The end of an operation is taken at the sample where `done` or `timeout` is first seen, with `busy` required low at that same sample. The elapsed time for a timeout is measured from the last WE rise and must lie between the budget and the budget plus one read length.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;

   typedef enum logic [1:0] {
      OP_PROG = 2'd0,
      OP_SECT = 2'd1,
      OP_CHIP = 2'd2
   } op_e;

   typedef enum logic [2:0] {
      B_IDLE, B_SET, B_WLO, B_WHI, B_TURN, B_OELO, B_REC
   } bus_st_e;

   typedef enum logic [2:0] {
      Q_IDLE, Q_WGO, Q_WWAIT, Q_RGO, Q_RWAIT
   } seq_st_e;

endpackage

// File: rtl/flash_seq_cmd.sv
module flash_seq_cmd
   import flash_seq_pkg::*;
#(
   parameter int AW = 18
) (
   input  op_e           op,
   input  logic [2:0]    idx,
   input  logic [AW-1:0] tgt_addr,
   input  logic [7:0]    tgt_data,
   output logic [AW-1:0] c_addr,
   output logic [7:0]    c_data,
   output logic [2:0]    n_steps
);

   localparam logic [AW-1:0] UNLK_A = AW'(16'h5555);
   localparam logic [AW-1:0] UNLK_B = AW'(16'h2AAA);

   generate
      if (AW < 15) begin : g_bad_aw
         $error("flash_seq_cmd: AW must cover the 15-bit unlock addresses");
      end
   endgenerate

   assign n_steps = (op == OP_PROG) ? 3'd4 : 3'd6;

   always_comb begin
      c_addr = UNLK_A;
      c_data = 8'hAA;
      case (idx)
         3'd0: begin c_addr = UNLK_A; c_data = 8'hAA; end
         3'd1: begin c_addr = UNLK_B; c_data = 8'h55; end
         3'd2: begin
            c_addr = UNLK_A;
            c_data = (op == OP_PROG) ? 8'hA0 : 8'h80;
         end
         3'd3: begin
            c_addr = (op == OP_PROG) ? tgt_addr : UNLK_A;
            c_data = (op == OP_PROG) ? tgt_data : 8'hAA;
         end
         3'd4: begin c_addr = UNLK_B; c_data = 8'h55; end
         default: begin
            c_addr = (op == OP_CHIP) ? UNLK_A : tgt_addr;
            c_data = (op == OP_CHIP) ? 8'h10 : 8'h30;
         end
      endcase
   end

endmodule

// File: rtl/flash_seq_bus.sv
module flash_seq_bus
   import flash_seq_pkg::*;
#(
   parameter int AW    = 18,
   parameter int T_AS  = 1,
   parameter int T_WP  = 7,
   parameter int T_WPH = 4,
   parameter int T_OE  = 9,
   parameter int T_OEH = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic          is_rd,
   input  logic [AW-1:0] addr,
   input  logic [7:0]    wdata,
   output logic          done,
   output logic [1:0]    rstat,
   output logic [AW-1:0] fl_addr,
   output logic [7:0]    fl_dout,
   output logic          fl_dout_en,
   input  logic [1:0]    fl_stat,
   output logic          fl_ce_n,
   output logic          fl_oe_n,
   output logic          fl_we_n
);

   localparam int M1   = (T_AS > T_WP) ? T_AS : T_WP;
   localparam int M2   = (T_WPH > T_OE) ? T_WPH : T_OE;
   localparam int M3   = (M1 > M2) ? M1 : M2;
   localparam int MAXT = (M3 > T_OEH) ? M3 : T_OEH;
   localparam int CW   = $clog2(MAXT + 1);

   generate
      if (T_AS < 1 || T_WP < 1 || T_WPH < 1 || T_OE < 1 || T_OEH < 1) begin : g_bad_t
         $error("flash_seq_bus: every phase length must be at least one cycle");
      end
   endgenerate

   bus_st_e       st, nxt;
   logic [CW-1:0] cnt;
   logic [AW-1:0] a_q;
   logic [7:0]    d_q;
   logic [1:0]    s_q;
   logic          done_q;
   int            lim;
   logic          last;

   always_comb begin
      case (st)
         B_SET:   begin lim = T_AS;  nxt = B_WLO;  end
         B_WLO:   begin lim = T_WP;  nxt = B_WHI;  end
         B_WHI:   begin lim = T_WPH; nxt = B_IDLE; end
         B_TURN:  begin lim = 1;     nxt = B_OELO; end
         B_OELO:  begin lim = T_OE;  nxt = B_REC;  end
         B_REC:   begin lim = T_OEH; nxt = B_IDLE; end
         default: begin lim = 1;     nxt = B_IDLE; end
      endcase
   end

   assign last = (cnt == CW'(lim - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st     <= B_IDLE;
         cnt    <= '0;
         a_q    <= '0;
         d_q    <= '0;
         s_q    <= '0;
         done_q <= 1'b0;
      end else begin
         done_q <= 1'b0;
         if (st == B_IDLE) begin
            if (start) begin
               a_q <= addr;
               d_q <= wdata;
               cnt <= '0;
               st  <= is_rd ? B_TURN : B_SET;
            end
         end else if (last) begin
            cnt <= '0;
            st  <= nxt;
            if (st == B_OELO) s_q <= fl_stat;
            if (st == B_WHI || st == B_REC) done_q <= 1'b1;
         end else begin
            cnt <= cnt + 1'b1;
         end
      end
   end

   assign done       = done_q;
   assign rstat      = s_q;
   assign fl_addr    = a_q;
   assign fl_dout    = d_q;
   assign fl_ce_n    = (st == B_IDLE);
   assign fl_we_n    = (st != B_WLO);
   assign fl_oe_n    = (st != B_OELO);
   assign fl_dout_en = (st == B_SET) || (st == B_WLO) || (st == B_WHI);

   // WE low-time monitor for the width property below
   logic [CW:0] wlo_cnt;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             wlo_cnt <= '0;
      else if (fl_we_n)       wlo_cnt <= '0;
      else if (wlo_cnt != '1) wlo_cnt <= wlo_cnt + 1'b1;
   end

   p_we_width_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(fl_we_n) |-> (wlo_cnt >= (CW+1)'(T_WP)));

   p_drive_off_before_oe_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(fl_oe_n) |-> $past(!fl_dout_en));

   p_we_needs_drive_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !fl_we_n |-> (fl_dout_en && !fl_ce_n));

endmodule

// File: rtl/flash_seq_poll.sv
module flash_seq_poll
   import flash_seq_pkg::*;
#(
   parameter int TO_PROG = 4000,
   parameter int TO_SECT = 2000000,
   parameter int TO_CHIP = 400000000
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       clr,
   input  logic       run,
   input  logic       rd_valid,
   input  logic [1:0] rstat,
   input  logic       use_toggle,
   input  op_e        op,
   input  logic       exp7,
   output logic       success,
   output logic       expired
);

   localparam int MX    = (TO_PROG > TO_SECT) ? TO_PROG : TO_SECT;
   localparam int MAXTO = (MX > TO_CHIP) ? MX : TO_CHIP;
   localparam int TW    = $clog2(MAXTO + 1);

   generate
      if (TO_PROG < 1 || TO_SECT < 1 || TO_CHIP < 1) begin : g_bad_to
         $error("flash_seq_poll: cycle budgets must be positive");
      end
   endgenerate

   logic [TW-1:0] cnt;
   logic [TW-1:0] lim;
   logic          prev6;
   logic          have_prev;

   always_comb begin
      case (op)
         OP_PROG: lim = TW'(TO_PROG);
         OP_SECT: lim = TW'(TO_SECT);
         default: lim = TW'(TO_CHIP);
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt       <= '0;
         prev6     <= 1'b0;
         have_prev <= 1'b0;
      end else if (clr) begin
         cnt       <= '0;
         have_prev <= 1'b0;
      end else begin
         if (run && cnt < TW'(MAXTO)) cnt <= cnt + 1'b1;
         if (rd_valid) begin
            prev6     <= rstat[0];
            have_prev <= 1'b1;
         end
      end
   end

   assign expired = (cnt >= lim);
   assign success = rd_valid &&
                    (use_toggle ? (have_prev && (prev6 == rstat[0]))
                                : (rstat[1] == exp7));

endmodule

// File: rtl/flash_seq.sv
module flash_seq
   import flash_seq_pkg::*;
#(
   parameter int AW      = 18,
   parameter int T_AS    = 1,
   parameter int T_WP    = 7,
   parameter int T_WPH   = 4,
   parameter int T_OE    = 9,
   parameter int T_OEH   = 2,
   parameter int TO_PROG = 4000,
   parameter int TO_SECT = 2000000,
   parameter int TO_CHIP = 400000000
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          req_valid,
   input  logic [1:0]    req_op,
   input  logic [AW-1:0] req_addr,
   input  logic [7:0]    req_data,
   input  logic          req_toggle,
   output logic          busy,
   output logic          done,
   output logic          timeout,
   output logic [AW-1:0] fl_addr,
   output logic [7:0]    fl_dout,
   output logic          fl_dout_en,
   input  logic [1:0]    fl_stat,
   output logic          fl_ce_n,
   output logic          fl_oe_n,
   output logic          fl_we_n
);

   seq_st_e       st;
   op_e           op_q;
   logic [AW-1:0] addr_q;
   logic [7:0]    data_q;
   logic          tog_q;
   logic [2:0]    idx;
   logic          done_q, tmo_q;

   logic [AW-1:0] c_addr;
   logic [7:0]    c_data;
   logic [2:0]    n_steps;
   logic          last_step;
   logic          b_done;
   logic [1:0]    b_stat;
   logic          p_ok, p_exp;
   logic          accept;

   assign accept    = req_valid && (st == Q_IDLE) && (req_op != 2'd3);
   assign last_step = (idx == 3'(n_steps - 3'd1));

   flash_seq_cmd #(.AW(AW)) u_cmd (
      .op       (op_q),
      .idx      (idx),
      .tgt_addr (addr_q),
      .tgt_data (data_q),
      .c_addr   (c_addr),
      .c_data   (c_data),
      .n_steps  (n_steps)
   );

   flash_seq_bus #(
      .AW(AW), .T_AS(T_AS), .T_WP(T_WP), .T_WPH(T_WPH), .T_OE(T_OE), .T_OEH(T_OEH)
   ) u_bus (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      ((st == Q_WGO) || (st == Q_RGO)),
      .is_rd      (st == Q_RGO),
      .addr       ((st == Q_RGO) ? addr_q : c_addr),
      .wdata      (c_data),
      .done       (b_done),
      .rstat      (b_stat),
      .fl_addr    (fl_addr),
      .fl_dout    (fl_dout),
      .fl_dout_en (fl_dout_en),
      .fl_stat    (fl_stat),
      .fl_ce_n    (fl_ce_n),
      .fl_oe_n    (fl_oe_n),
      .fl_we_n    (fl_we_n)
   );

   flash_seq_poll #(
      .TO_PROG(TO_PROG), .TO_SECT(TO_SECT), .TO_CHIP(TO_CHIP)
   ) u_poll (
      .clk        (clk),
      .rst_n      (rst_n),
      .clr        ((st == Q_WWAIT) && b_done && last_step),
      .run        ((st == Q_RGO) || (st == Q_RWAIT)),
      .rd_valid   ((st == Q_RWAIT) && b_done),
      .rstat      (b_stat),
      .use_toggle (tog_q),
      .op         (op_q),
      .exp7       (p_exp),
      .success    (p_ok),
      .expired    (p_exp_out)
   );

   logic p_exp_out;
   assign p_exp = (op_q == OP_PROG) ? data_q[7] : 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st     <= Q_IDLE;
         op_q   <= OP_PROG;
         addr_q <= '0;
         data_q <= '0;
         tog_q  <= 1'b0;
         idx    <= '0;
         done_q <= 1'b0;
         tmo_q  <= 1'b0;
      end else begin
         done_q <= 1'b0;
         tmo_q  <= 1'b0;
         case (st)
            Q_IDLE: if (accept) begin
               op_q   <= op_e'(req_op);
               addr_q <= req_addr;
               data_q <= req_data;
               tog_q  <= req_toggle;
               idx    <= '0;
               st     <= Q_WGO;
            end
            Q_WGO: st <= Q_WWAIT;
            Q_WWAIT: if (b_done) begin
               if (last_step) st <= Q_RGO;
               else begin
                  idx <= idx + 3'd1;
                  st  <= Q_WGO;
               end
            end
            Q_RGO: st <= Q_RWAIT;
            Q_RWAIT: if (b_done) begin
               if (p_ok) begin
                  done_q <= 1'b1;
                  st     <= Q_IDLE;
               end else if (p_exp_out) begin
                  tmo_q <= 1'b1;
                  st    <= Q_IDLE;
               end else begin
                  st <= Q_RGO;
               end
            end
            default: st <= Q_IDLE;
         endcase
      end
   end

   assign busy    = (st != Q_IDLE);
   assign done    = done_q;
   assign timeout = tmo_q;

   p_oe_we_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !(!fl_oe_n && !fl_we_n));

   p_busy_end_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> (done || timeout));

   p_end_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !(done && timeout));

   p_accept_legal_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> ($past(req_valid) && ($past(req_op) != 2'd3)));

   p_read_we_high_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !fl_oe_n |-> (fl_we_n && !fl_ce_n));

endmodule

// File: tb/sim_flash_seq.sv
`timescale 1ns/100ps
module sim_flash_seq;

   localparam int AW      = 18;
   localparam int T_AS    = 1;
   localparam int T_WP    = 2;
   localparam int T_WPH   = 2;
   localparam int T_OE    = 2;
   localparam int T_OEH   = 1;
   localparam int TO_PROG = 60;
   localparam int TO_SECT = 120;
   localparam int TO_CHIP = 200;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic [1:0]    req_op = 2'd0;
   logic [AW-1:0] req_addr = '0;
   logic [7:0]    req_data = '0;
   logic          req_toggle = 1'b0;
   logic          busy, done, timeout;
   logic [AW-1:0] fl_addr;
   logic [7:0]    fl_dout;
   logic          fl_dout_en, fl_ce_n, fl_oe_n, fl_we_n;
   logic [7:0]    din = 8'h00;

   always #2.5 clk = ~clk;

   flash_seq #(
      .AW(AW), .T_AS(T_AS), .T_WP(T_WP), .T_WPH(T_WPH), .T_OE(T_OE), .T_OEH(T_OEH),
      .TO_PROG(TO_PROG), .TO_SECT(TO_SECT), .TO_CHIP(TO_CHIP)
   ) u0 (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
      .req_addr(req_addr), .req_data(req_data), .req_toggle(req_toggle),
      .busy(busy), .done(done), .timeout(timeout),
      .fl_addr(fl_addr), .fl_dout(fl_dout), .fl_dout_en(fl_dout_en),
      .fl_stat({din[7], din[6]}), .fl_ce_n(fl_ce_n), .fl_oe_n(fl_oe_n), .fl_we_n(fl_we_n)
   );

   // ---------------- flash model and bus monitor (falling-edge sampled)
   int            plan_dur = 0;
   bit            plan_stuck = 1'b0;
   logic [7:0]    mem [256];
   logic [AW-1:0] wa [8];
   logic [7:0]    wd [8];
   int            nw = 0, nrd = 0, viol = 0, cyc = 0, last_rise = 0, fin_cyc = 0;
   int            m_busy = 0, wl = 0;
   bit            m_stuck = 1'b0, m_tog = 1'b0, m_b7 = 1'b0;
   int            m_kind = 0;
   logic [AW-1:0] m_addr = '0, cap_a = '0, p_addr = '0;
   logic [7:0]    m_data = '0, cap_d = '0;
   bit            p_we = 1'b1, p_oe = 1'b1, p_en = 1'b0, p_ce = 1'b1, p_busy = 1'b0;

   initial for (int i = 0; i < 256; i++) mem[i] = 8'(i * 37 + 5);

   always @(negedge clk) begin
      if (rst_n) begin
         cyc++;
         if (busy && !p_busy) begin nw = 0; nrd = 0; end
         if (!busy && p_busy) begin m_busy = 0; m_stuck = 1'b0; end
         if (m_busy > 0 && !m_stuck) begin
            m_busy--;
            if (m_busy == 0) begin
               fin_cyc = cyc;
               if (m_kind == 0) mem[m_addr[7:0]] = m_data;
               else if (m_kind == 2) for (int i = 0; i < 256; i++) mem[i] = 8'hFF;
               else for (int i = 0; i < 256; i++)
                  if (i[7:4] == m_addr[7:4]) mem[i] = 8'hFF;
            end
         end
         if (fl_dout_en && !fl_oe_n) viol++;
         if (!fl_we_n && (fl_ce_n || !fl_oe_n || !fl_dout_en)) viol++;
         if (!fl_we_n && p_we) begin
            cap_a = fl_addr; cap_d = fl_dout; wl = 1;
            if (!p_en || p_ce || p_addr != fl_addr) viol++;
         end else if (!fl_we_n) begin
            wl++;
            if (fl_addr != cap_a || fl_dout != cap_d) viol++;
         end
         if (fl_we_n && !p_we) begin
            if (wl < T_WP) viol++;
            if (fl_addr != cap_a || !fl_dout_en || fl_ce_n) viol++;
            last_rise = cyc;
            if (nw < 8) begin wa[nw] = cap_a; wd[nw] = fl_dout; end
            nw++;
            if ((nw == 4 && wd[2] == 8'hA0) || (nw == 6 && wd[2] == 8'h80)) begin
               m_kind  = (nw == 4) ? 0 : ((wd[5] == 8'h10) ? 2 : 1);
               m_addr  = wa[nw-1];
               m_data  = wd[nw-1];
               m_b7    = (m_kind == 0) ? wd[3][7] : 1'b1;
               m_busy  = plan_dur + 1;
               m_stuck = plan_stuck;
            end
         end
         if (!fl_oe_n && p_oe) begin
            if (p_en || !fl_we_n) viol++;
            nrd++;
            if (m_busy > 0) m_tog = ~m_tog;
         end
         din = (m_busy > 0) ? {~m_b7, m_tog, 6'h00} : mem[fl_addr[7:0]];
         p_we = fl_we_n; p_oe = fl_oe_n; p_en = fl_dout_en; p_ce = fl_ce_n;
         p_addr = fl_addr; p_busy = busy;
      end
   end

   // ---------------- checking
   int nchk = 0, nfail = 0;

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      nchk++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic tick();
      @(negedge clk);
      #1;
   endtask

   function automatic logic [AW-1:0] e_addr(int op, int i, logic [AW-1:0] a);
      case (i)
         0, 2:    return AW'(16'h5555);
         1, 4:    return AW'(16'h2AAA);
         3:       return (op == 0) ? a : AW'(16'h5555);
         default: return (op == 2) ? AW'(16'h5555) : a;
      endcase
   endfunction

   function automatic logic [7:0] e_data(int op, int i, logic [7:0] d);
      case (i)
         0, 3:    return (i == 3 && op == 0) ? d : 8'hAA;
         1, 4:    return 8'h55;
         2:       return (op == 0) ? 8'hA0 : 8'h80;
         default: return (op == 2) ? 8'h10 : 8'h30;
      endcase
   endfunction

   function automatic int limit_of(int op);
      return (op == 0) ? TO_PROG : ((op == 1) ? TO_SECT : TO_CHIP);
   endfunction

   task automatic run_op(input int op, input logic [AW-1:0] a, input logic [7:0] d,
                         input bit tg, input int dur, input bit stuck, input bit poke,
                         input int exp_reads);
      int  v0, w, nst;
      bit  got_done, got_tmo;
      plan_dur = dur; plan_stuck = stuck;
      v0 = viol;
      req_valid = 1'b1; req_op = 2'(op); req_addr = a; req_data = d; req_toggle = tg;
      tick();
      req_valid = 1'b0;
      chk(busy == 1'b1, "R2 busy after accept", busy, 1);
      chk(fl_ce_n == 1'b1 && fl_we_n == 1'b1, "R6 bus quiet at accept", fl_we_n, 1);
      for (int i = 1; i <= T_AS; i++) begin
         tick();
         if (i == 1) chk(fl_ce_n == 1'b0, "R6 CE low one cycle after accept", fl_ce_n, 0);
         chk(fl_we_n == 1'b1, "R6 WE still high in setup", fl_we_n, 1);
      end
      tick();
      chk(fl_we_n == 1'b0, "R6 WE falls at T_AS+1", fl_we_n, 0);
      if (poke) begin
         req_valid = 1'b1; req_op = 2'd2; req_addr = '0; req_toggle = 1'b0;
         tick();
         req_valid = 1'b0;
      end
      w = 0;
      while (!(done || timeout) && w < 5000) begin tick(); w++; end
      got_done = done; got_tmo = timeout;
      chk(busy == 1'b0, "R2 busy low with end pulse", busy, 0);
      chk(!(got_done && got_tmo), "R2 done and timeout exclusive", got_done, 0);
      nst = (op == 0) ? 4 : 6;
      chk(nw == nst, (op == 0) ? "R3 program write count" : "R4 erase write count", nw, nst);
      for (int i = 0; i < nst && i < 8; i++) begin
         chk(wa[i] == e_addr(op, i, a), (op == 0) ? "R3 write address" : "R4 write address",
             wa[i], e_addr(op, i, a));
         chk(wd[i] == e_data(op, i, d), (op == 0) ? "R3 write data" : "R4 write data",
             wd[i], e_data(op, i, d));
      end
      chk(viol == v0, "R5 R7 bus timing violations", viol - v0, 0);
      if (stuck) begin
         chk(got_tmo == 1'b1, "R10 timeout reported", got_tmo, 1);
         chk((cyc - last_rise) >= limit_of(op) && (cyc - last_rise) <= limit_of(op) + 40,
             "R10 timeout elapsed cycles", cyc - last_rise, limit_of(op));
      end else begin
         chk(got_done == 1'b1, tg ? "R9 toggle done" : "R8 polling done", got_done, 1);
         chk(cyc > fin_cyc, tg ? "R9 done after flash ready" : "R8 done after flash ready",
             cyc - fin_cyc, 1);
         if (tg) chk(nrd >= 2, "R9 at least two reads", nrd, 2);
         if (exp_reads > 0)
            chk(nrd == exp_reads, tg ? "R9 read count" : "R8 read count", nrd, exp_reads);
         chk(mem[a[7:0]] == ((op == 0) ? d : 8'hFF), "R8 target content", mem[a[7:0]],
             (op == 0) ? d : 8'hFF);
      end
      if (poke) begin
         int n0 = nw;
         bit quiet = 1'b1;
         for (int i = 0; i < 12; i++) begin
            tick();
            if (busy || !fl_ce_n) quiet = 1'b0;
         end
         chk(quiet && nw == n0, "R1 request during busy ignored", busy, 0);
      end
      repeat (3) tick();
   endtask

   initial begin
      void'($urandom(32'd4242));
      repeat (3) tick();
      chk(busy == 1'b0 && done == 1'b0 && timeout == 1'b0, "R11 reset outputs", busy, 0);
      chk(fl_ce_n && fl_oe_n && fl_we_n && !fl_dout_en, "R11 reset bus idle",
          {fl_ce_n, fl_oe_n, fl_we_n, fl_dout_en}, 4'b1110);
      rst_n = 1'b1;
      repeat (2) tick();

      // illegal operation code is ignored
      begin
         bit quiet = 1'b1;
         req_valid = 1'b1; req_op = 2'd3; req_addr = AW'(18'h00123);
         tick();
         req_valid = 1'b0;
         for (int i = 0; i < 10; i++) begin
            if (busy || !fl_ce_n || !fl_we_n) quiet = 1'b0;
            tick();
         end
         chk(quiet, "R1 illegal op ignored", busy, 0);
      end

      // directed corners
      run_op(0, AW'(18'h01A42), 8'h3C, 1'b0, 0, 1'b0, 1'b0, 1);   // immediate, bit7 = 0
      run_op(0, AW'(18'h20081), 8'hC5, 1'b1, 0, 1'b0, 1'b0, 2);   // toggle needs two reads
      run_op(0, AW'(18'h000F7), 8'h80, 1'b0, 20, 1'b0, 1'b1, 0);  // poke while busy
      run_op(1, AW'(18'h3C0A5), 8'h00, 1'b0, 40, 1'b0, 1'b0, 0);  // sector erase, polling
      run_op(2, AW'(18'h00010), 8'h00, 1'b1, 50, 1'b0, 1'b0, 0);  // chip erase, toggle
      run_op(0, AW'(18'h00033), 8'h11, 1'b1, 0, 1'b1, 1'b0, 0);   // program timeout
      run_op(1, AW'(18'h00050), 8'h00, 1'b0, 0, 1'b1, 1'b0, 0);   // sector timeout
      run_op(2, AW'(18'h00000), 8'h00, 1'b1, 0, 1'b1, 1'b0, 0);   // chip timeout

      // constrained random
      for (int k = 0; k < 14; k++) begin
         int            op  = $urandom_range(2, 0);
         logic [AW-1:0] a   = AW'($urandom);
         logic [7:0]    d   = 8'($urandom);
         bit            tg  = 1'($urandom);
         bit            stk = ($urandom_range(4, 0) == 0);
         int            dur = $urandom_range(limit_of(op) / 3, 0);
         run_op(op, a, d, tg, dur, stk, 1'b0, 0);
      end

      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      nchk++; nfail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 150000, 0);
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
   end

endmodule